// File: doc/BRIEF.md
# Page Walk Memory Request Scheduler

This block sits between a page table walker and a memory port that is allowed to turn requests away. The walker hands it at most one table read at a time and any number of accessed-bit write-backs, up to a parameter-sized queue. The scheduler offers them to the port one per cycle over a valid/ready handshake. A table read always goes ahead of the write-backs. If the port turns a request away, the scheduler goes quiet until the port signals that it may try again.

Memory responses come back on a separate channel. A response may carry a negative acknowledge. In that case the request it echoes is loaded back into the scheduler: a read returns to the read slot and a write returns to the tail of the write-back queue, and both are offered again. Good read data goes back to the walker one cycle after it arrives. The scheduler keeps a count of accepted requests that have not yet been answered. It raises a one-cycle walk-complete pulse only once the read slot is empty, the queue is empty and that count is zero.

Every request carries an uncacheable flag. The flag reaches the port unchanged, whether the request is sent for the first time or re-sent after a negative acknowledge.

Top module: `ptw_req_sched`

## Requirements
- R1: While a read is pending, any request offered on the port is that read (`mem_req_write` = 0). Queued write-backs are offered only when no read is pending.
- R2: A request that is offered while `mem_req_ready` is low is turned away. From the next cycle on, `mem_req_valid` stays low until a `mem_retry` pulse arrives. The cycle after that pulse, offering resumes in the R1 order.
- R3: `walk_done` is never high while an accepted request still awaits its response.
- R4: A response with `mem_rsp_nack` = 1 causes the echoed request to be offered again with the same address, data, direction and uncacheable flag. For a read, `mem_rsp_write` = 0; for a write, `mem_rsp_write` = 1.
- R5: A read response with no nack raises `wk_rsp_valid` for exactly one cycle, in the cycle after it arrives, with `wk_rsp_data` equal to `mem_rsp_data`. Write responses and nacks raise nothing.
- R6: `walk_done` is a single-cycle pulse. It comes in the cycle after the first cycle in which a started walk has no pending read, an empty queue, nothing outstanding and no new push. A walker that pushes its next read in the cycle `wk_rsp_valid` is high gets no pulse between the two reads.
- R7: Write-backs reach the port in the order they were pushed.
- R8: `wk_rd_ready` is low while a read is pending or outstanding. `wk_wr_ready` is low while the queued write-backs plus the outstanding requests number `WQ_DEPTH` or more. A push made while the matching ready is low is ignored.
- R9: `mem_req_unc` equals the uncacheable flag that the walker gave with the request, or that the nack response echoed.
- R10: After reset, `mem_req_valid`, `wk_rsp_valid` and `walk_done` are low, and both walker readies are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wk_rd_push | input | 1 | Walker places a table read |
| wk_rd_addr | input | ADDR_W | Read address |
| wk_rd_unc | input | 1 | Read uncacheable flag |
| wk_rd_ready | output | 1 | Read slot free |
| wk_wr_push | input | 1 | Walker places an accessed-bit write-back |
| wk_wr_addr | input | ADDR_W | Write-back address |
| wk_wr_data | input | DATA_W | Write-back data |
| wk_wr_unc | input | 1 | Write-back uncacheable flag |
| wk_wr_ready | output | 1 | Write-back queue has room |
| wk_rsp_valid | output | 1 | Read data returned to the walker |
| wk_rsp_data | output | DATA_W | Returned read data |
| walk_done | output | 1 | Walk fully drained (pulse) |
| mem_req_valid | output | 1 | Request offered to memory |
| mem_req_ready | input | 1 | Memory takes the request this cycle |
| mem_req_write | output | 1 | 1 write, 0 read |
| mem_req_addr | output | ADDR_W | Request address |
| mem_req_wdata | output | DATA_W | Write data, zero for reads |
| mem_req_unc | output | 1 | Uncacheable flag |
| mem_retry | input | 1 | Memory invites a new attempt after a refusal |
| mem_rsp_valid | input | 1 | Response arrives |
| mem_rsp_nack | input | 1 | Response is a negative acknowledge |
| mem_rsp_write | input | 1 | Response belongs to a write |
| mem_rsp_addr | input | ADDR_W | Echoed request address |
| mem_rsp_wdata | input | DATA_W | Echoed write data |
| mem_rsp_unc | input | 1 | Echoed uncacheable flag |
| mem_rsp_data | input | DATA_W | Read data |

## Verification
A walker push and a port refusal can fall in the same cycle. The bench provokes this by holding `mem_req_ready` low while it pushes a read and further write-backs behind a write that has already been turned away. After the retry pulse, the scoreboard requires the read first and then the writes in push order, and it rejects any handshake that was not expected. A response that decrements the outstanding count can also coincide with the walker's next read push. The bench times that push into the `wk_rsp_valid` cycle and judges it by the absence of a `walk_done` pulse between the two reads.

// File: rtl/ptw_sched_pkg.sv
package ptw_sched_pkg;
  typedef enum logic [1:0] {
    PICK_NONE  = 2'd0,
    PICK_READ  = 2'd1,
    PICK_WRITE = 2'd2
  } pick_e;
endpackage

// File: rtl/ptw_wb_fifo.sv
module ptw_wb_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_a,
  input  logic [WIDTH-1:0] din_a,
  input  logic             push_b,
  input  logic [WIDTH-1:0] din_b,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [CW-1:0]    count,
  output logic             empty
);
  logic [WIDTH-1:0] store [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p, input int n);
    int s;
    s = int'(p) + n;
    if (s >= DEPTH) s = s - DEPTH;
    return PW'(s);
  endfunction

  // push_a (replayed write) lands ahead of push_b (walker write) in the same cycle
  always_ff @(posedge clk) begin
    if (push_a) store[wr_ptr] <= din_a;
    if (push_b) store[push_a ? step(wr_ptr, 1) : wr_ptr] <= din_b;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= step(wr_ptr, int'(push_a) + int'(push_b));
      if (pop) rd_ptr <= step(rd_ptr, 1);
      count <= CW'(int'(count) + int'(push_a) + int'(push_b) - int'(pop));
    end
  end

  assign dout  = store[rd_ptr];
  assign empty = (count == '0);

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(count) + int'(push_a) + int'(push_b) - int'(pop)) <= DEPTH);

  // R7
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> (count != '0));
endmodule

// File: rtl/ptw_port_tx.sv
module ptw_port_tx
  import ptw_sched_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_pend,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_unc,
  input  logic              wq_empty,
  input  logic [ADDR_W-1:0] wq_addr,
  input  logic [DATA_W-1:0] wq_data,
  input  logic              wq_unc,
  input  logic              mem_req_ready,
  input  logic              mem_retry,
  input  logic              rsp_seen,
  output logic              mem_req_valid,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  output logic              mem_req_unc,
  output logic              take_rd,
  output logic              take_wr,
  output logic [CNT_W-1:0]  inflight
);
  pick_e pick;
  logic  retrying;
  logic  fire;

  always_comb begin
    pick = PICK_NONE;
    if (!retrying) begin
      if (rd_pend)        pick = PICK_READ;
      else if (!wq_empty) pick = PICK_WRITE;
    end
  end

  assign mem_req_valid = (pick != PICK_NONE);
  assign mem_req_write = (pick == PICK_WRITE);
  assign mem_req_addr  = mem_req_write ? wq_addr : rd_addr;
  assign mem_req_wdata = mem_req_write ? wq_data : '0;
  assign mem_req_unc   = mem_req_write ? wq_unc  : rd_unc;

  assign fire    = mem_req_valid && mem_req_ready;
  assign take_rd = fire && (pick == PICK_READ);
  assign take_wr = fire && (pick == PICK_WRITE);

  always_ff @(posedge clk) begin
    if (rst) begin
      retrying <= 1'b0;
      inflight <= '0;
    end else begin
      if (mem_req_valid && !mem_req_ready) retrying <= 1'b1;
      else if (mem_retry)                  retrying <= 1'b0;
      inflight <= CNT_W'(int'(inflight) + int'(fire) - int'(rsp_seen));
    end
  end

  // R2
  quiet_after_refuse_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> !mem_req_valid);

  // R1
  read_first_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_req_write) |-> !rd_pend);

  // R3
  inflight_floor_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_seen |-> (inflight != '0));
endmodule

// File: rtl/ptw_req_sched.sv
module ptw_req_sched #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 64,
  parameter int WQ_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wk_rd_push,
  input  logic [ADDR_W-1:0] wk_rd_addr,
  input  logic              wk_rd_unc,
  output logic              wk_rd_ready,
  input  logic              wk_wr_push,
  input  logic [ADDR_W-1:0] wk_wr_addr,
  input  logic [DATA_W-1:0] wk_wr_data,
  input  logic              wk_wr_unc,
  output logic              wk_wr_ready,
  output logic              wk_rsp_valid,
  output logic [DATA_W-1:0] wk_rsp_data,
  output logic              walk_done,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  output logic              mem_req_unc,
  input  logic              mem_retry,
  input  logic              mem_rsp_valid,
  input  logic              mem_rsp_nack,
  input  logic              mem_rsp_write,
  input  logic [ADDR_W-1:0] mem_rsp_addr,
  input  logic [DATA_W-1:0] mem_rsp_wdata,
  input  logic              mem_rsp_unc,
  input  logic [DATA_W-1:0] mem_rsp_data
);
  localparam int EW    = 1 + ADDR_W + DATA_W;
  localparam int CW    = $clog2(WQ_DEPTH + 1);
  localparam int CNT_W = $clog2(WQ_DEPTH + 2);

  logic              rd_pend, rd_out, busy;
  logic [ADDR_W-1:0] rd_addr_q;
  logic              rd_unc_q;
  logic [CW-1:0]     wq_count;
  logic              wq_empty;
  logic [EW-1:0]     wq_head;
  logic              take_rd, take_wr;
  logic [CNT_W-1:0]  inflight;
  logic              rd_accept, wr_accept;
  logic              rsp_rd_ok, nack_rd, nack_wr, done_cond;

  assign wk_rd_ready = !rd_pend && !rd_out;
  assign wk_wr_ready = (int'(wq_count) + int'(inflight)) < WQ_DEPTH;
  assign rd_accept   = wk_rd_push && wk_rd_ready;
  assign wr_accept   = wk_wr_push && wk_wr_ready;

  assign rsp_rd_ok = mem_rsp_valid && !mem_rsp_nack && !mem_rsp_write;
  assign nack_rd   = mem_rsp_valid &&  mem_rsp_nack && !mem_rsp_write;
  assign nack_wr   = mem_rsp_valid &&  mem_rsp_nack &&  mem_rsp_write;

  ptw_wb_fifo #(.DEPTH(WQ_DEPTH), .WIDTH(EW)) i_wb_fifo (
    .clk    (clk),
    .rst    (rst),
    .push_a (nack_wr),
    .din_a  ({mem_rsp_unc, mem_rsp_addr, mem_rsp_wdata}),
    .push_b (wr_accept),
    .din_b  ({wk_wr_unc, wk_wr_addr, wk_wr_data}),
    .pop    (take_wr),
    .dout   (wq_head),
    .count  (wq_count),
    .empty  (wq_empty)
  );

  ptw_port_tx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) i_port_tx (
    .clk           (clk),
    .rst           (rst),
    .rd_pend       (rd_pend),
    .rd_addr       (rd_addr_q),
    .rd_unc        (rd_unc_q),
    .wq_empty      (wq_empty),
    .wq_addr       (wq_head[EW-2 -: ADDR_W]),
    .wq_data       (wq_head[DATA_W-1:0]),
    .wq_unc        (wq_head[EW-1]),
    .mem_req_ready (mem_req_ready),
    .mem_retry     (mem_retry),
    .rsp_seen      (mem_rsp_valid),
    .mem_req_valid (mem_req_valid),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_req_unc   (mem_req_unc),
    .take_rd       (take_rd),
    .take_wr       (take_wr),
    .inflight      (inflight)
  );

  // read slot: one read pending or outstanding at any time
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pend   <= 1'b0;
      rd_out    <= 1'b0;
      rd_addr_q <= '0;
      rd_unc_q  <= 1'b0;
    end else begin
      if (rd_accept) begin
        rd_pend   <= 1'b1;
        rd_addr_q <= wk_rd_addr;
        rd_unc_q  <= wk_rd_unc;
      end else if (nack_rd) begin
        rd_pend   <= 1'b1;
        rd_addr_q <= mem_rsp_addr;
        rd_unc_q  <= mem_rsp_unc;
      end else if (take_rd) begin
        rd_pend   <= 1'b0;
      end
      if (take_rd)                             rd_out <= 1'b1;
      else if (mem_rsp_valid && !mem_rsp_write) rd_out <= 1'b0;
    end
  end

  assign done_cond = busy && !rd_pend && !rd_out && wq_empty &&
                     (inflight == '0) && !rd_accept && !wr_accept;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy         <= 1'b0;
      walk_done    <= 1'b0;
      wk_rsp_valid <= 1'b0;
      wk_rsp_data  <= '0;
    end else begin
      if (rd_accept || wr_accept) busy <= 1'b1;
      else if (done_cond)         busy <= 1'b0;
      walk_done    <= done_cond;
      wk_rsp_valid <= rsp_rd_ok;
      if (rsp_rd_ok) wk_rsp_data <= mem_rsp_data;
    end
  end

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    walk_done |=> !walk_done);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    walk_done |-> ((inflight == '0) && wq_empty && !rd_pend));

  // R8
  single_read_chk: assert property (@(posedge clk) disable iff (rst)
    rd_pend |-> !rd_out);

  // R5
  rsp_from_read_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rsp_valid && !mem_rsp_write) |-> rd_out);
endmodule

// File: tb/test_ptw_req_sched.sv
module test_ptw_req_sched;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 64;
  localparam int DEPTH  = 4;
  localparam int IW     = 2 + ADDR_W + DATA_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wk_rd_push = 0, wk_rd_unc = 0, wk_wr_push = 0, wk_wr_unc = 0;
  logic [ADDR_W-1:0] wk_rd_addr = '0, wk_wr_addr = '0, mem_rsp_addr = '0;
  logic [DATA_W-1:0] wk_wr_data = '0, mem_rsp_wdata = '0, mem_rsp_data = '0;
  logic mem_req_ready = 1'b1, mem_retry = 0;
  logic mem_rsp_valid = 0, mem_rsp_nack = 0, mem_rsp_write = 0, mem_rsp_unc = 0;
  logic wk_rd_ready, wk_wr_ready, wk_rsp_valid, walk_done;
  logic [DATA_W-1:0] wk_rsp_data, mem_req_wdata;
  logic mem_req_valid, mem_req_write, mem_req_unc;
  logic [ADDR_W-1:0] mem_req_addr;

  ptw_req_sched #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WQ_DEPTH(DEPTH)) i_ptw_req_sched (
    .clk(clk), .rst(rst),
    .wk_rd_push(wk_rd_push), .wk_rd_addr(wk_rd_addr), .wk_rd_unc(wk_rd_unc),
    .wk_rd_ready(wk_rd_ready),
    .wk_wr_push(wk_wr_push), .wk_wr_addr(wk_wr_addr), .wk_wr_data(wk_wr_data),
    .wk_wr_unc(wk_wr_unc), .wk_wr_ready(wk_wr_ready),
    .wk_rsp_valid(wk_rsp_valid), .wk_rsp_data(wk_rsp_data), .walk_done(walk_done),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_req_unc(mem_req_unc), .mem_retry(mem_retry),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_nack(mem_rsp_nack),
    .mem_rsp_write(mem_rsp_write), .mem_rsp_addr(mem_rsp_addr),
    .mem_rsp_wdata(mem_rsp_wdata), .mem_rsp_unc(mem_rsp_unc),
    .mem_rsp_data(mem_rsp_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails = 0;
  int done_cnt = 0;
  int outstanding = 0;
  bit finished = 0;
  logic [IW-1:0]     exp_req[$];
  logic [DATA_W-1:0] exp_rsp[$];

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic exp_push(input logic wr, input logic unc,
                          input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    exp_req.push_back({wr, unc, a, d});
  endtask

  // monitor: samples a quarter period after the falling edge
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (!rst) begin
        if (mem_req_valid && mem_req_ready) begin
          if (exp_req.size() == 0) begin
            chk("R1 R8 unexpected request addr", longint'(mem_req_addr), 0);
            checks--;
            fails += (mem_req_addr == 0) ? 1 : 0;
          end else begin
            logic [IW-1:0] e;
            e = exp_req.pop_front();
            chk("R1 direction", longint'(mem_req_write), longint'(e[IW-1]));
            chk("R9 uncacheable", longint'(mem_req_unc), longint'(e[IW-2]));
            chk("R7 address", longint'(mem_req_addr), longint'(e[DATA_W +: ADDR_W]));
            chk("R7 wdata", longint'(mem_req_wdata), longint'(e[DATA_W-1:0]));
          end
          outstanding++;
        end
        if (mem_rsp_valid) outstanding--;
        if (wk_rsp_valid) begin
          if (exp_rsp.size() == 0) chk("R5 unexpected wk_rsp_valid", 1, 0);
          else chk("R5 read data", longint'(wk_rsp_data), longint'(exp_rsp.pop_front()));
        end
        if (walk_done) begin
          done_cnt++;
          chk("R3 outstanding at done", longint'(outstanding), 0);
          chk("R3 unsent at done", longint'(exp_req.size()), 0);
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_rd(input logic [ADDR_W-1:0] a, input logic u);
    @(negedge clk);
    wk_rd_push = 1; wk_rd_addr = a; wk_rd_unc = u;
    @(negedge clk);
    wk_rd_push = 0;
  endtask

  task automatic push_wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                         input logic u);
    @(negedge clk);
    wk_wr_push = 1; wk_wr_addr = a; wk_wr_data = d; wk_wr_unc = u;
    @(negedge clk);
    wk_wr_push = 0;
  endtask

  task automatic drive_rsp(input logic wr, input logic nk, input logic [ADDR_W-1:0] a,
                           input logic [DATA_W-1:0] d, input logic u);
    mem_rsp_valid = 1; mem_rsp_write = wr; mem_rsp_nack = nk; mem_rsp_addr = a;
    mem_rsp_unc = u;
    if (wr) mem_rsp_wdata = d; else mem_rsp_data = d;
  endtask

  task automatic send_rsp(input logic wr, input logic nk, input logic [ADDR_W-1:0] a,
                          input logic [DATA_W-1:0] d, input logic u);
    @(negedge clk);
    drive_rsp(wr, nk, a, d, u);
    @(negedge clk);
    mem_rsp_valid = 0; mem_rsp_nack = 0;
  endtask

  task automatic retry_pulse;
    @(negedge clk);
    mem_retry = 1;
    @(negedge clk);
    mem_retry = 0;
  endtask

  task automatic expect_done(input string tag);
    int start;
    start = done_cnt;
    for (int i = 0; i < 12 && done_cnt == start; i++) @(negedge clk);
    chk(tag, longint'(done_cnt - start), 1);
    idle(4);
    chk({tag, " single pulse"}, longint'(done_cnt - start), 1);
  endtask

  initial begin
    int d0;
    idle(3);
    rst = 0;
    @(negedge clk);
    #(CLK_PERIOD/4);
    // R10 reset state
    chk("R10 mem_req_valid", longint'(mem_req_valid), 0);
    chk("R10 wk_rsp_valid", longint'(wk_rsp_valid), 0);
    chk("R10 walk_done", longint'(walk_done), 0);
    chk("R10 wk_rd_ready", longint'(wk_rd_ready), 1);
    chk("R10 wk_wr_ready", longint'(wk_wr_ready), 1);

    // A: refusal, read priority, order, write responses delaying completion
    mem_req_ready = 0;
    push_wr(32'h1000, 64'hA1, 1'b1);
    idle(3);
    chk("R2 quiet after refusal", longint'(mem_req_valid), 0);
    push_rd(32'h2000, 1'b0);
    push_wr(32'h1008, 64'hA2, 1'b0);
    idle(3);
    chk("R2 still quiet without retry", longint'(mem_req_valid), 0);
    chk("R8 rd ready low while read pending", longint'(wk_rd_ready), 0);
    exp_push(0, 0, 32'h2000, 64'h0);
    exp_push(1, 1, 32'h1000, 64'hA1);
    exp_push(1, 0, 32'h1008, 64'hA2);
    exp_rsp.push_back(64'hD00D);
    mem_req_ready = 1;
    retry_pulse();
    idle(5);
    chk("R1 R2 all issued after retry", longint'(exp_req.size()), 0);
    chk("R8 rd ready low while read outstanding", longint'(wk_rd_ready), 0);
    d0 = done_cnt;
    send_rsp(0, 0, 32'h2000, 64'hD00D, 0);
    idle(4);
    chk("R3 no done with writes outstanding", longint'(done_cnt - d0), 0);
    chk("R8 rd ready back after response", longint'(wk_rd_ready), 1);
    send_rsp(1, 0, 32'h1000, 64'hA1, 1);
    idle(3);
    chk("R3 no done with one write outstanding", longint'(done_cnt - d0), 0);
    send_rsp(1, 0, 32'h1008, 64'hA2, 0);
    expect_done("R6 done after drain");

    // B: nack of a read, then nack of a write
    exp_push(0, 1, 32'h3000, 64'h0);
    push_rd(32'h3000, 1'b1);
    idle(3);
    exp_push(0, 1, 32'h3000, 64'h0);
    send_rsp(0, 1, 32'h3000, 64'h0, 1);
    idle(4);
    chk("R4 read re-offered after nack", longint'(exp_req.size()), 0);
    exp_rsp.push_back(64'hBEEF);
    send_rsp(0, 0, 32'h3000, 64'hBEEF, 1);
    expect_done("R6 done after nacked read");
    exp_push(1, 1, 32'h4000, 64'hC3);
    push_wr(32'h4000, 64'hC3, 1'b1);
    idle(3);
    exp_push(1, 1, 32'h4000, 64'hC3);
    send_rsp(1, 1, 32'h4000, 64'hC3, 1);
    idle(4);
    chk("R4 write re-offered after nack", longint'(exp_req.size()), 0);
    send_rsp(1, 0, 32'h4000, 64'hC3, 1);
    expect_done("R6 done after nacked write");

    // C: queue full stall, ignored push, order of many writes
    mem_req_ready = 0;
    for (int i = 0; i < DEPTH; i++) push_wr(32'h5000 + 32'(i*8), 64'(i + 16), 1'(i));
    idle(1);
    chk("R8 wr ready low when full", longint'(wk_wr_ready), 0);
    push_wr(32'h5F00, 64'hFF, 1'b1);
    idle(2);
    for (int i = 0; i < DEPTH; i++) exp_push(1, 1'(i), 32'h5000 + 32'(i*8), 64'(i + 16));
    mem_req_ready = 1;
    retry_pulse();
    idle(8);
    chk("R7 all queued writes issued in order", longint'(exp_req.size()), 0);
    chk("R8 wr ready low while writes outstanding", longint'(wk_wr_ready), 0);
    for (int i = 0; i < DEPTH; i++) send_rsp(1, 0, 32'h5000 + 32'(i*8), 64'(i + 16), 1'(i));
    idle(1);
    chk("R8 wr ready back after drain", longint'(wk_wr_ready), 1);
    expect_done("R6 done after full queue");

    // D: next read pushed in the wk_rsp_valid cycle keeps the walk open
    exp_push(0, 0, 32'h6000, 64'h0);
    push_rd(32'h6000, 1'b0);
    idle(3);
    exp_rsp.push_back(64'h1111);
    exp_push(0, 1, 32'h6100, 64'h0);
    d0 = done_cnt;
    @(negedge clk);
    drive_rsp(0, 0, 32'h6000, 64'h1111, 0);
    @(negedge clk);
    mem_rsp_valid = 0;
    wk_rd_push = 1; wk_rd_addr = 32'h6100; wk_rd_unc = 1;
    @(negedge clk);
    wk_rd_push = 0;
    idle(4);
    chk("R6 no done between chained reads", longint'(done_cnt - d0), 0);
    exp_rsp.push_back(64'h2222);
    send_rsp(0, 0, 32'h6100, 64'h2222, 1);
    expect_done("R6 done after chained walk");
    chk("R5 all read data returned", longint'(exp_rsp.size()), 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule